// File: doc/BRIEF.md
# Order Quantity and Notional Limiter

This block screens one trading order at a time before it is forwarded. An order carries a quantity, a limit price and a side. The block forms the notional value as the full-width product of quantity and price. It compares quantity and notional against two ceilings held in a small register bank. For each ceiling, a mode bit chooses the action on a breach. The block either refuses the order, or shrinks the quantity to the largest value both ceilings allow and forwards the smaller order.

An accepted order is snapshotted together with the ceilings and mode bits that are live at that moment, so later register writes only affect later orders. The largest quantity the notional ceiling allows is found with an iterative restoring divider. The divider runs for every order, so the verdict always appears a fixed number of cycles after acceptance. The result is a single output beat that carries the verdict, a reason code, the possibly reduced quantity, and the unchanged price and side. It is held under valid/ready back-pressure.

Top module: `order_limiter`

## Requirements
- R1: An order whose quantity exceeds the quantity ceiling, while the quantity clip bit (mode bit 0) is clear, is refused: verdict 2, reason 1, output quantity 0. This check has priority over R2.
- R2: An order whose notional (quantity × price) exceeds the notional ceiling, while the notional clip bit (mode bit 1) is clear and R1 does not apply, is refused: verdict 2, reason 2, output quantity 0.
- R3: When every breached ceiling has its clip bit set, the output quantity is min(quantity, quantity ceiling, floor(notional ceiling / price)), with no notional bound at price 0. The verdict is 1, and the reason is 1 when the result equals the quantity ceiling, otherwise 2.
- R4: An order of quantity 0 is refused with reason 3. A clipped quantity that comes out as 0 is refused with reason 4. Both carry verdict 2 and output quantity 0.
- R5: An order within both ceilings passes: verdict 0, reason 0, quantity unchanged. Price and side are forwarded unchanged on every verdict.
- R6: The notional comparison uses the full QTY_W+PX_W-bit product. Products larger than the quantity range are compared exactly.
- R7: After reset, in_ready_o is 1 and out_valid_o is 0. While out_valid_o is high and out_ready_i is low, all result outputs hold and no new order is accepted. The beat is consumed on the first edge with out_ready_i high.
- R8: Register writes (address 0 quantity ceiling, 1 notional ceiling, 2 mode bits) made while an order is being checked do not change that order's result. They apply to the next order.
- R9: out_valid_o is first high after the (QTY_W+PX_W+1)th rising edge following the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Order offered |
| in_ready_o | output | 1 | Block idle and able to take an order |
| in_qty_i | input | QTY_W | Order quantity |
| in_px_i | input | PX_W | Order limit price |
| in_side_i | input | 1 | Order side, passed through |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select: 0 quantity ceiling, 1 notional ceiling, 2 mode bits |
| cfg_wdata_i | input | QTY_W+PX_W | Register write data |
| out_valid_o | output | 1 | Result beat valid |
| out_ready_i | input | 1 | Downstream takes the beat |
| out_verdict_o | output | 2 | 0 pass, 1 clipped, 2 refused |
| out_reason_o | output | 3 | 0 none, 1 quantity, 2 notional, 3 zero quantity, 4 clipped to zero |
| out_qty_o | output | QTY_W | Forwarded quantity |
| out_px_o | output | PX_W | Forwarded price |
| out_side_o | output | 1 | Forwarded side |

## Verification
The block is built with 4-bit quantity and price. Every quantity and price pair is swept under all four mode combinations and four ceiling pairs. The ceiling pairs include a zero quantity ceiling and a notional ceiling below most prices, which separate pass, clip to either bound, clip to zero and each refusal priority. Products above 15 show whether the notional is formed at full width. Directed cases cover a stalled output, a register write landing mid-check, and the first order after reset.

// File: rtl/olim_pkg.sv
package olim_pkg;
  typedef enum logic [1:0] {
    VERD_PASS   = 2'd0,
    VERD_CLIP   = 2'd1,
    VERD_REJECT = 2'd2
  } verdict_e;

  typedef enum logic [2:0] {
    RSN_NONE      = 3'd0,
    RSN_QTY       = 3'd1,
    RSN_NTL       = 3'd2,
    RSN_ZERO_QTY  = 3'd3,
    RSN_ZERO_CLIP = 3'd4
  } reason_e;

  localparam logic [1:0] CFG_MAX_QTY = 2'd0;
  localparam logic [1:0] CFG_MAX_NTL = 2'd1;
  localparam logic [1:0] CFG_MODE    = 2'd2;
endpackage

// File: rtl/olim_limit_regs.sv
module olim_limit_regs
  import olim_pkg::*;
#(
  parameter int QTY_W = 16,
  parameter int NTL_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [NTL_W-1:0] wdata_i,
  output logic [QTY_W-1:0] max_qty_o,
  output logic [NTL_W-1:0] max_ntl_o,
  output logic             clip_qty_o,
  output logic             clip_ntl_o
);
  // reset to zero ceilings, refuse mode: safe until programmed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_qty_o  <= '0;
      max_ntl_o  <= '0;
      clip_qty_o <= 1'b0;
      clip_ntl_o <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        CFG_MAX_QTY: max_qty_o <= wdata_i[QTY_W-1:0];
        CFG_MAX_NTL: max_ntl_o <= wdata_i;
        CFG_MODE: begin
          clip_qty_o <= wdata_i[0];
          clip_ntl_o <= wdata_i[1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/olim_divider.sv
module olim_divider #(
  parameter int NTL_W = 32,
  parameter int PX_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NTL_W-1:0] dividend_i,
  input  logic [PX_W-1:0]  divisor_i,
  output logic [NTL_W-1:0] quot_o,
  output logic             done_o
);
  localparam int CNT_W = (NTL_W > 1) ? $clog2(NTL_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NTL_W - 1);

  logic [NTL_W-1:0] dvd_q, dvd0_q, quo_q;
  logic [PX_W-1:0]  div_q, rem_q, diff;
  logic [PX_W:0]    shifted;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, ge;

  assign shifted = {rem_q, dvd_q[NTL_W-1]};
  assign ge      = shifted >= {1'b0, div_q};
  // true difference is below divisor, so it fits PX_W bits
  assign diff    = shifted[PX_W-1:0] - div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      dvd0_q <= '0;
      quo_q  <= '0;
      div_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        dvd_q  <= dividend_i;
        dvd0_q <= dividend_i;
        div_q  <= divisor_i;
        quo_q  <= '0;
        rem_q  <= '0;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? diff : shifted[PX_W-1:0];
        quo_q <= {quo_q[NTL_W-2:0], ge};
        dvd_q <= dvd_q << 1;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;

  logic [NTL_W+PX_W-1:0] chk_prod, chk_dvd, chk_div;
  assign chk_prod = {{PX_W{1'b0}}, quo_q} * {{NTL_W{1'b0}}, div_q};
  assign chk_dvd  = {{PX_W{1'b0}}, dvd0_q};
  assign chk_div  = {{NTL_W{1'b0}}, div_q};

  // quotient is the exact floor: q*d <= n < (q+1)*d
  assert_div_exact_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_q != '0) |-> (chk_prod <= chk_dvd && (chk_dvd - chk_prod) < chk_div));
  // divide by zero saturates, leaving no notional bound
  assert_div_zero_sat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_q == '0) |-> (&quo_q));
endmodule

// File: rtl/olim_verdict.sv
module olim_verdict
  import olim_pkg::*;
#(
  parameter int QTY_W = 16,
  parameter int NTL_W = 32
) (
  input  logic [QTY_W-1:0] qty_i,
  input  logic [NTL_W-1:0] ntl_i,
  input  logic [QTY_W-1:0] max_qty_i,
  input  logic [NTL_W-1:0] max_ntl_i,
  input  logic [QTY_W-1:0] bound_i,
  input  logic             clip_qty_i,
  input  logic             clip_ntl_i,
  output verdict_e         verdict_o,
  output reason_e          reason_o,
  output logic [QTY_W-1:0] qty_o
);
  logic             qty_brk, ntl_brk;
  logic [QTY_W-1:0] allowed;

  assign qty_brk = qty_i > max_qty_i;
  assign ntl_brk = ntl_i > max_ntl_i;

  always_comb begin
    allowed = qty_i;
    if (max_qty_i < allowed) allowed = max_qty_i;
    if (bound_i < allowed)   allowed = bound_i;
  end

  always_comb begin
    verdict_o = VERD_REJECT;
    reason_o  = RSN_NONE;
    qty_o     = '0;
    if (qty_i == '0) begin
      reason_o = RSN_ZERO_QTY;
    end else if (qty_brk && !clip_qty_i) begin
      reason_o = RSN_QTY;
    end else if (ntl_brk && !clip_ntl_i) begin
      reason_o = RSN_NTL;
    end else if (!qty_brk && !ntl_brk) begin
      verdict_o = VERD_PASS;
      qty_o     = qty_i;
    end else if (allowed == '0) begin
      reason_o = RSN_ZERO_CLIP;
    end else begin
      verdict_o = VERD_CLIP;
      reason_o  = (allowed == max_qty_i) ? RSN_QTY : RSN_NTL;
      qty_o     = allowed;
    end
  end
endmodule

// File: rtl/order_limiter.sv
module order_limiter
  import olim_pkg::*;
#(
  parameter int QTY_W = 16,
  parameter int PX_W  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [QTY_W-1:0]      in_qty_i,
  input  logic [PX_W-1:0]       in_px_i,
  input  logic                  in_side_i,
  input  logic                  cfg_we_i,
  input  logic [1:0]            cfg_addr_i,
  input  logic [QTY_W+PX_W-1:0] cfg_wdata_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [1:0]            out_verdict_o,
  output logic [2:0]            out_reason_o,
  output logic [QTY_W-1:0]      out_qty_o,
  output logic [PX_W-1:0]       out_px_o,
  output logic                  out_side_o
);
  localparam int NTL_W = QTY_W + PX_W;

  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_OUT} st_e;
  st_e state_q;

  logic [QTY_W-1:0] cfg_max_qty;
  logic [NTL_W-1:0] cfg_max_ntl;
  logic             cfg_clip_qty, cfg_clip_ntl;

  logic [QTY_W-1:0] qty_q, mq_q, bound, vd_qty, res_qty_q;
  logic [PX_W-1:0]  px_q;
  logic [NTL_W-1:0] ntl_q, mn_q, quot, ntl_d;
  logic             side_q, cq_q, cn_q, accept, div_done;
  verdict_e         vd_verdict, res_verd_q;
  reason_e          vd_reason, res_rsn_q;

  olim_limit_regs #(.QTY_W(QTY_W), .NTL_W(NTL_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .max_qty_o(cfg_max_qty), .max_ntl_o(cfg_max_ntl),
    .clip_qty_o(cfg_clip_qty), .clip_ntl_o(cfg_clip_ntl)
  );

  assign in_ready_o = (state_q == ST_IDLE);
  assign accept     = in_valid_i && in_ready_o;
  // full-width product, never overflows
  assign ntl_d      = NTL_W'(in_qty_i) * NTL_W'(in_px_i);

  olim_divider #(.NTL_W(NTL_W), .PX_W(PX_W)) u_div (
    .clk_i, .rst_ni,
    .start_i(accept), .dividend_i(cfg_max_ntl), .divisor_i(in_px_i),
    .quot_o(quot), .done_o(div_done)
  );

  assign bound = (|quot[NTL_W-1:QTY_W]) ? '1 : quot[QTY_W-1:0];

  olim_verdict #(.QTY_W(QTY_W), .NTL_W(NTL_W)) u_verdict (
    .qty_i(qty_q), .ntl_i(ntl_q), .max_qty_i(mq_q), .max_ntl_i(mn_q),
    .bound_i(bound), .clip_qty_i(cq_q), .clip_ntl_i(cn_q),
    .verdict_o(vd_verdict), .reason_o(vd_reason), .qty_o(vd_qty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      qty_q      <= '0;
      px_q       <= '0;
      side_q     <= 1'b0;
      ntl_q      <= '0;
      mq_q       <= '0;
      mn_q       <= '0;
      cq_q       <= 1'b0;
      cn_q       <= 1'b0;
      res_verd_q <= VERD_PASS;
      res_rsn_q  <= RSN_NONE;
      res_qty_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          // snapshot order and limits so later writes cannot disturb this check
          qty_q   <= in_qty_i;
          px_q    <= in_px_i;
          side_q  <= in_side_i;
          ntl_q   <= ntl_d;
          mq_q    <= cfg_max_qty;
          mn_q    <= cfg_max_ntl;
          cq_q    <= cfg_clip_qty;
          cn_q    <= cfg_clip_ntl;
          state_q <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          res_verd_q <= vd_verdict;
          res_rsn_q  <= vd_reason;
          res_qty_q  <= vd_qty;
          state_q    <= ST_OUT;
        end
        ST_OUT: if (out_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid_o   = (state_q == ST_OUT);
  assign out_verdict_o = res_verd_q;
  assign out_reason_o  = res_rsn_q;
  assign out_qty_o     = res_qty_q;
  assign out_px_o      = px_q;
  assign out_side_o    = side_q;

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_verdict_o)
      && $stable(out_reason_o) && $stable(out_qty_o) && $stable(out_px_o)));
  assert_no_take_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);
  assert_qty_refuse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_verdict_o == VERD_REJECT && out_reason_o == RSN_QTY)
      |-> (qty_q > mq_q && !cq_q && out_qty_o == '0));
  assert_ntl_refuse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_verdict_o == VERD_REJECT && out_reason_o == RSN_NTL)
      |-> (ntl_q > mn_q && !cn_q && out_qty_o == '0));
  assert_clip_shrinks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_verdict_o == VERD_CLIP)
      |-> (out_qty_o < qty_q && out_qty_o <= mq_q && out_qty_o != '0));
  assert_zero_refused_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && qty_q == '0) |-> (out_verdict_o == VERD_REJECT && out_reason_o == RSN_ZERO_QTY));
  assert_pass_intact_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_verdict_o == VERD_PASS) |-> (out_reason_o == RSN_NONE && out_qty_o == qty_q));
  // multiplier and divider must agree on the notional breach
  assert_ntl_bound_agree_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DIV && div_done && px_q != '0)
      |-> ((ntl_q > mn_q) == ({{PX_W{1'b0}}, qty_q} > quot)));
endmodule

// File: tb/tb_order_limiter.sv
module tb_order_limiter;
  localparam int QW  = 4;
  localparam int PW  = 4;
  localparam int NW  = QW + PW;
  localparam int LAT = NW + 1;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          in_valid = 1'b0, in_side = 1'b0, cfg_we = 1'b0, out_ready = 1'b1;
  logic [QW-1:0] in_qty = '0;
  logic [PW-1:0] in_px = '0;
  logic [1:0]    cfg_addr = '0;
  logic [NW-1:0] cfg_wdata = '0;
  logic          in_ready, out_valid, out_side;
  logic [1:0]    out_verdict;
  logic [2:0]    out_reason;
  logic [QW-1:0] out_qty;
  logic [PW-1:0] out_px;

  int total = 0, bad = 0;
  int cur_mq = 0, cur_mn = 0, cur_cq = 0, cur_cn = 0;

  always #2 clk = ~clk;

  order_limiter #(.QTY_W(QW), .PX_W(PW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_qty_i(in_qty), .in_px_i(in_px), .in_side_i(in_side),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_verdict_o(out_verdict), .out_reason_o(out_reason),
    .out_qty_o(out_qty), .out_px_o(out_px), .out_side_o(out_side)
  );

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end

  task automatic cfg_write(input logic [1:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = NW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_cfg(input int mq, input int mn, input int mode);
    cfg_write(2'd0, mq);
    cfg_write(2'd1, mn);
    cfg_write(2'd2, mode);
    cur_mq = mq; cur_mn = mn; cur_cq = mode & 1; cur_cn = (mode >> 1) & 1;
  endtask

  // arithmetic model from the requirements
  task automatic model(input int q, input int p, output int v, output int r,
                       output int oq, output string tag);
    int ntl, bnd, a;
    ntl = q * p;
    bnd = (p == 0) ? 1000 : cur_mn / p;
    a = q;
    if (cur_mq < a) a = cur_mq;
    if (bnd < a) a = bnd;
    oq = 0; v = 2;
    if (q == 0)                        begin r = 3; tag = "R4"; end
    else if (q > cur_mq && cur_cq == 0) begin r = 1; tag = "R1"; end
    else if (ntl > cur_mn && cur_cn == 0) begin r = 2; tag = "R2"; end
    else if (a == q)                   begin v = 0; r = 0; oq = q; tag = "R5"; end
    else if (a == 0)                   begin r = 4; tag = "R4"; end
    else begin v = 1; oq = a; r = (a == cur_mq) ? 1 : 2; tag = "R3"; end
    if (ntl > 15) tag = {tag, ",R6"};
  endtask

  task automatic run_order(input int q, input int p, input logic s);
    int v, r, oq, n;
    string tag;
    model(q, p, v, r, oq, tag);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_qty = QW'(q); in_px = PW'(p); in_side = s;
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (!out_valid && n < 100) begin @(negedge clk); n++; end
    total++;
    if (out_verdict != 2'(v) || out_reason != 3'(r) || out_qty != QW'(oq)
        || out_px != PW'(p) || out_side != s) begin
      bad++;
      $display("FAIL %s q=%0d p=%0d mq=%0d mn=%0d mode=%0d%0d: actual v=%0d r=%0d qty=%0d px=%0d side=%0b expected v=%0d r=%0d qty=%0d px=%0d side=%0b",
               tag, q, p, cur_mq, cur_mn, cur_cn, cur_cq, out_verdict, out_reason, out_qty,
               out_px, out_side, v, r, oq, p, s);
    end
    if (n != LAT) begin
      bad++;
      $display("FAIL R9 latency: actual %0d expected %0d", n, LAT);
    end
  endtask

  initial begin
    logic [1:0] hv; logic [2:0] hr; logic [QW-1:0] hq;
    logic ok;
    int cfgs_mq[4] = '{10, 15, 5, 0};
    int cfgs_mn[4] = '{60, 255, 20, 3};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (!(in_ready == 1'b1 && out_valid == 1'b0)) begin
      bad++;
      $display("FAIL R7 reset: actual ready=%0b valid=%0b expected ready=1 valid=0", in_ready, out_valid);
    end
    // reset ceilings are zero and refuse mode: quantity check wins (R1)
    run_order(1, 1, 1'b0);

    // exhaustive sweeps over ceilings and modes (R1 R2 R3 R4 R5 R6)
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++) begin
        set_cfg(cfgs_mq[c], cfgs_mn[c], m);
        for (int q = 0; q < 16; q++)
          for (int p = 0; p < 16; p++)
            run_order(q, p, logic'((q ^ p) & 1));
      end

    // back-pressure hold (R7)
    set_cfg(6, 30, 3);
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_qty = 4'd9; in_px = 4'd4; in_side = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    hv = out_verdict; hr = out_reason; hq = out_qty;
    ok = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (!out_valid || in_ready || out_verdict != hv || out_reason != hr || out_qty != hq) ok = 1'b0;
    end
    total++;
    // min(9,6,30/4=7)=6 -> clip on quantity
    if (!ok || hv != 2'd1 || hr != 3'd1 || hq != 4'd6) begin
      bad++;
      $display("FAIL R7 hold: actual v=%0d r=%0d qty=%0d stable=%0b expected v=1 r=1 qty=6 stable=1", hv, hr, hq, ok);
    end
    out_ready = 1'b1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      bad++;
      $display("FAIL R7 consume: actual valid=%0b ready=%0b expected valid=0 ready=1", out_valid, in_ready);
    end

    // write during a check applies only to later orders (R8)
    set_cfg(8, 255, 0);
    @(negedge clk);
    in_valid = 1'b1; in_qty = 4'd10; in_px = 4'd1; in_side = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = NW'(12);
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 2'd2; cfg_wdata = NW'(3);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    while (!out_valid) @(negedge clk);
    total++;
    if (out_verdict != 2'd2 || out_reason != 3'd1 || out_qty != 4'd0) begin
      bad++;
      $display("FAIL R8 in-flight: actual v=%0d r=%0d qty=%0d expected v=2 r=1 qty=0", out_verdict, out_reason, out_qty);
    end
    cur_mq = 12; cur_cq = 1; cur_cn = 1;
    run_order(10, 1, 1'b1);   // R8: now passes under new ceiling
    run_order(14, 1, 1'b0);   // R8: new clip mode clips to 12

    finish_run();
  end
endmodule